// File: doc/BRIEF.md
# Windowed Clock Presence Monitor

This block tells a design whether a second, monitored clock is toggling. A clock cannot observe its own absence, so all decisions are made in a stable reference clock domain. The monitored clock can first be divided by a power of two in its own domain. The divided signal then passes through a two-stage synchronizer into the reference domain. A third register keeps the previous sample, which lets the block find rising edges, falling edges or both, as a parameter selects.

A free-running reference counter cuts time into fixed windows of `WIN_LEN` reference cycles. The block counts the detected transitions inside each window. At each window end, the registered flag `clk_alive` is set if the count reached `MIN_EDGES` and cleared otherwise. The flag is 0 after reset and only rises once real activity has been seen. This holds even when the reference runs for a long time and the monitored clock stays silent. The window length must be chosen so that it holds at least one expected transition at the slowest supported monitored frequency. The divide ratio must be high enough that the divided signal toggles at no more than half the reference rate.

Top module: `clk_presence_monitor`

## Requirements
- R1: `clk_alive` is 0 while `rst_n` is low and stays 0 for any number of windows after reset in which no monitored transition arrives.
- R2: `clk_alive` changes only at window ends, which are spaced exactly `WIN_LEN` reference cycles apart, so any two changes of the flag are a whole number of windows apart.
- R3: The per-window transition count saturates at 2^`CNT_W`-1 and never wraps. With `CNT_W`=4 and 32 transitions in one window, the flag still reads 1.
- R4: At a window end the flag becomes 1 if that window held at least `MIN_EDGES` counted transitions, and 0 if it held fewer.
- R5: `EDGE_MODE` selects the transitions that are counted: rising only (`EDGE_RISE`), falling only (`EDGE_FALL`) or both (`EDGE_BOTH`).
- R6: The monitored clock is divided by 2^`DIV_LOG2` before synchronization, with the divider reset asynchronously by `rst_n`. `DIV_LOG2`=0 passes the monitored clock straight through.
- R7: After the monitored clock stops, `clk_alive` is 0 no later than 2*`WIN_LEN`+4 reference cycles after the last transition.
- R8: After the monitored clock restarts, `clk_alive` is 1 no later than 2*`WIN_LEN`+4 reference cycles after the first transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Stable reference clock; all detection logic runs on it |
| rst_n | input | 1 | Active-low reset, asynchronous, shared by both domains |
| mon_clk | input | 1 | Clock whose presence is monitored |
| clk_alive | output | 1 | 1 while the monitored clock is seen toggling, updated at window ends |

## Verification
The monitored clock is driven at several periods, from two reference cycles up to many hundreds of nanoseconds, and is stopped between some of them. Fast periods push the count past its saturation limit, which separates a saturating counter from a wrapping one. Slow periods put only one or two rising edges in a window. On a second instance that counts rising edges only, bypasses the divider and needs three transitions, this separates the edge modes and the threshold. A stop followed by a restart measures the fall and rise latency against the two-window bound. It also checks that the two flag changes lie a whole number of windows apart.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2
  } edge_sel_e;

  // Decide whether a pair of consecutive samples forms a counted transition.
  function automatic logic edge_found(input logic prev_s, input logic cur_s,
                                      input edge_sel_e sel);
    logic hit;
    case (sel)
      EDGE_RISE: hit = cur_s & ~prev_s;
      EDGE_FALL: hit = ~cur_s & prev_s;
      default:   hit = cur_s ^ prev_s;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/cpm_divider.sv
module cpm_divider #(
  parameter int DIV_LOG2 = 1
) (
  input  logic mon_clk,
  input  logic rst_n,
  output logic div_out
);

  generate
    if (DIV_LOG2 == 0) begin : g_bypass
      assign div_out = mon_clk;
    end else begin : g_div
      logic [DIV_LOG2-1:0] stage_q;
      always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_q + 1'b1;
      end
      assign div_out = stage_q[DIV_LOG2-1];
    end
  endgenerate

endmodule

// File: rtl/cpm_sync_edge.sv
module cpm_sync_edge
  import cpm_pkg::*;
#(
  parameter edge_sel_e EDGE_MODE = EDGE_BOTH
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_hit
);

  logic meta_q, sync_q, prev_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign edge_hit = edge_found(prev_q, sync_q, EDGE_MODE);

endmodule

// File: rtl/cpm_window.sv
module cpm_window #(
  parameter int WIN_LEN = 64
) (
  input  logic ref_clk,
  input  logic rst_n,
  output logic win_end
);

  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_LEN - 1);

  logic [WIN_W-1:0] tick_q;

  assign win_end = (tick_q == LAST);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)       tick_q <= '0;
    else if (win_end) tick_q <= '0;
    else              tick_q <= tick_q + 1'b1;
  end

endmodule

// File: rtl/cpm_status.sv
module cpm_status #(
  parameter int CNT_W     = 4,
  parameter int MIN_EDGES = 1
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             edge_hit,
  input  logic             win_end,
  output logic [CNT_W-1:0] edge_cnt,
  output logic             alive
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] THRESH  = CNT_W'(MIN_EDGES);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] tally;

  always_comb tally = edge_hit ? sat_inc(edge_cnt) : edge_cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      alive    <= 1'b0;
    end else if (win_end) begin
      edge_cnt <= '0;
      alive    <= (tally >= THRESH);
    end else begin
      edge_cnt <= tally;
    end
  end

endmodule

// File: rtl/clk_presence_monitor.sv
module clk_presence_monitor
  import cpm_pkg::*;
#(
  parameter int        DIV_LOG2  = 1,
  parameter edge_sel_e EDGE_MODE = EDGE_BOTH,
  parameter int        WIN_LEN   = 64,
  parameter int        CNT_W     = 4,
  parameter int        MIN_EDGES = 1
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic clk_alive
);

  logic             div_sig;
  logic             edge_hit;
  logic             win_end;
  logic [CNT_W-1:0] edge_cnt;

  cpm_divider #(.DIV_LOG2(DIV_LOG2)) u_div (
    .mon_clk (mon_clk),
    .rst_n   (rst_n),
    .div_out (div_sig)
  );

  cpm_sync_edge #(.EDGE_MODE(EDGE_MODE)) u_sync (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .async_in (div_sig),
    .edge_hit (edge_hit)
  );

  cpm_window #(.WIN_LEN(WIN_LEN)) u_win (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .win_end (win_end)
  );

  cpm_status #(.CNT_W(CNT_W), .MIN_EDGES(MIN_EDGES)) u_stat (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .edge_hit (edge_hit),
    .win_end  (win_end),
    .edge_cnt (edge_cnt),
    .alive    (clk_alive)
  );

endmodule

// File: rtl/cpm_checker.sv
module cpm_checker #(
  parameter int WIN_LEN   = 64,
  parameter int CNT_W     = 4,
  parameter int MIN_EDGES = 1
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic             edge_hit,
  input logic             win_end,
  input logic [CNT_W-1:0] edge_cnt,
  input logic             clk_alive
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic seen_edge;
  int   gap;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_edge <= 1'b0;
      gap       <= 0;
    end else begin
      if (edge_hit) seen_edge <= 1'b1;
      gap <= win_end ? 0 : gap + 1;
    end
  end

  // R1: the flag never claims activity before a transition was seen
  p_no_early_alive_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    clk_alive |-> seen_edge);

  // R2: the flag holds between window ends
  p_hold_between_windows_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !win_end |=> $stable(clk_alive));

  // R2: window ends spaced by the window length (counter, not a deep $past)
  p_window_spacing_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    gap < WIN_LEN);

  // R3: a full count stays full until the window closes
  p_no_overflow_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (edge_cnt == CNT_MAX && !win_end) |=> edge_cnt == CNT_MAX);

  // R4: an empty window clears the flag
  p_empty_window_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (MIN_EDGES >= 1 && win_end && edge_cnt == '0 && !edge_hit) |=> !clk_alive);

  // R4: the flag only rises right after a window end
  p_rise_at_end_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(clk_alive) |-> $past(win_end));

endmodule

bind clk_presence_monitor cpm_checker #(
  .WIN_LEN(WIN_LEN), .CNT_W(CNT_W), .MIN_EDGES(MIN_EDGES)
) u_cpm_chk (
  .ref_clk   (ref_clk),
  .rst_n     (rst_n),
  .edge_hit  (edge_hit),
  .win_end   (win_end),
  .edge_cnt  (edge_cnt),
  .clk_alive (clk_alive)
);

// File: tb/tb_clk_presence_monitor.sv
`timescale 1ns/1ps
module tb_clk_presence_monitor;
  import cpm_pkg::*;

  localparam int WIN = 64;
  localparam int SETTLE = 2 * WIN + 4;

  logic ref_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic mon_clk = 1'b0;
  logic alive_main, alive_min;
  int   mon_half = 0;
  int   n_chk = 0, n_fail = 0;
  int   cyc = 0;
  int   last_change = 0;
  logic prev_alive = 1'b0;

  always #10 ref_clk = ~ref_clk;

  initial begin
    #7;
    forever begin
      if (mon_half == 0) begin
        mon_clk = 1'b0;
        #5;
      end else begin
        #(mon_half) mon_clk = ~mon_clk;
      end
    end
  end

  // main: divide by 2, both edges, threshold 1
  clk_presence_monitor #(.DIV_LOG2(1), .EDGE_MODE(EDGE_BOTH), .WIN_LEN(WIN),
                         .CNT_W(4), .MIN_EDGES(1)) dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk), .clk_alive(alive_main));

  // second: bypass, rising only, threshold 3
  clk_presence_monitor #(.DIV_LOG2(0), .EDGE_MODE(EDGE_RISE), .WIN_LEN(WIN),
                         .CNT_W(4), .MIN_EDGES(3)) dut_min (
    .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk), .clk_alive(alive_min));

  always @(negedge ref_clk) begin
    cyc <= cyc + 1;
    if (alive_main !== prev_alive) last_change <= cyc;
    prev_alive <= alive_main;
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  // half period ns, expected main flag, expected rising-only/threshold-3 flag
  typedef struct packed { int half; logic exp_main; logic exp_min; } vec_t;
  localparam vec_t VECS [7] = '{
    '{25,  1'b1, 1'b1},   // R4 R6 fast clock
    '{500, 1'b1, 1'b0},   // R5 R6 one or two rising edges per window
    '{0,   1'b0, 1'b0},   // R4 stopped
    '{20,  1'b1, 1'b1},   // R3 32 transitions per window in main
    '{200, 1'b1, 1'b1},   // R4 three or more rising edges
    '{0,   1'b0, 1'b0},   // R4 stopped again
    '{100, 1'b1, 1'b1}    // R4 medium
  };

  initial begin
    int fall_at, rise_at;
    wait_cyc(5);
    check("R1 reset main", alive_main, 1'b0);
    rst_n = 1'b1;
    wait_cyc(1);
    check("R1 after release", alive_main, 1'b0);
    wait_cyc(4 * WIN);
    check("R1 idle monitored clock main", alive_main, 1'b0);
    check("R1 idle monitored clock min", alive_min, 1'b0);

    foreach (VECS[i]) begin
      mon_half = VECS[i].half;
      wait_cyc(3 * WIN);
      check($sformatf("R4 vec%0d main", i), alive_main, VECS[i].exp_main);
      check($sformatf("R5 R6 vec%0d min", i), alive_min, VECS[i].exp_min);
    end

    // R7: stop, flag must fall within the bound
    mon_half = 0;
    wait_cyc(3);
    wait_cyc(SETTLE);
    check("R7 fall after stop", alive_main, 1'b0);
    fall_at = last_change;

    // R8: restart, flag must rise within the bound
    mon_half = 25;
    wait_cyc(SETTLE);
    check("R8 rise after restart", alive_main, 1'b1);
    rise_at = last_change;

    // R2: changes lie on window boundaries
    n_chk++;
    if (((rise_at - fall_at) % WIN) != 0) begin
      n_fail++;
      $display("FAIL R2: change spacing actual %0d expected multiple of %0d",
               rise_at - fall_at, WIN);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule